// File: doc/BRIEF.md
# Streaming Packet Receive Checker

This block sits on the receive side of a packet stream and checks what arrives. Each cycle it offers a read enable. A word moves in on any cycle where that read enable and the source's valid are both high. The first word of a packet carries the start marker, and its data value gives the packet's total length in words, header included. The words after it carry a payload that counts up from zero. The block counts the words that come in and compares that count with the header length when the end marker arrives. It checks every payload value, and it catches start markers and end markers that are missing.

Two outputs report the outcome. One is a running count of packets whose length matched, which a test environment compares with the number of packets it sent. The other is a single sticky error flag. The read enable also depends on the source's data-available signal. A build-time mode sets whether that signal gates every read or only the read of each packet's first word. A gap-enable input makes the read enable follow a pseudo-random bit, which puts read gaps inside packets.

The core is a two-state machine. In IDLE no packet is open. The transition IDLE to BODY, called *open*, happens when an accepted start word has no end marker. The transition BODY to IDLE, called *close*, happens when an accepted word carries the end marker. An accepted start word that also carries the end marker is a *single*, which keeps the machine in IDLE. A start word that arrives in BODY is a *restart*: it is reported as an error and then opens a new packet, so the machine stays in BODY unless that word also carries the end marker. A word without a start marker that arrives in IDLE is an *orphan*: it is reported as an error and the machine stays in IDLE.

Top module: `pkt_rx_checker`

## Requirements
- R1: After a synchronous active-high reset, pkt_count is 0 and err is 0. With gap_en low, rd_en then equals dav.
- R2: A word is accepted only on a cycle where rd_en and valid are both high. Markers and data on cycles with valid low have no effect.
- R3: The data value of the start word is the packet length in words, header included. At the end word, a difference between that length and the number of words accepted sets err, and pkt_count does not increase.
- R4: An accepted end word whose length matched increases pkt_count by exactly one, visible in the cycle after the acceptance. pkt_count changes at no other time.
- R5: The payload words expected after the header are 0, 1, 2 and so on, restarting at 0 with every start word and wrapping at the data width. A payload word with any other value sets err.
- R6: A start word accepted while a packet is open sets err. That start word then opens a new packet.
- R7: A word without a start marker accepted while no packet is open sets err. The machine stays in IDLE.
- R8: Once err is set, it stays high until reset.
- R9: With gap_en high, rd_en is high only when bit 0 of a 16-bit LFSR is 1. The LFSR is loaded with 16'hACE1 on reset and on every other cycle steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R10: With PRIORITY=0, rd_en is low whenever dav is low.
- R11: With PRIORITY=1, dav gates rd_en only while no packet is open, and is ignored for the rest of an open packet.
- R12: A start word that also carries the end marker and holds length 1 is a complete good packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gap_en | input | 1 | Gates rd_en with the pseudo-random bit |
| dav | input | 1 | Source has data available |
| valid | input | 1 | Source drives a word this cycle |
| sop | input | 1 | Start-of-packet marker |
| eop | input | 1 | End-of-packet marker |
| data | input | W | Word data: length in the start word, payload after it |
| rd_en | output | 1 | Read enable to the source |
| pkt_count | output | CNT_W | Number of packets whose length matched |
| err | output | 1 | Sticky error flag |

## Verification
The checker is given clean packets of length 1, 2 and 4. Some are sent back to back and some have idle cycles between words, during which sop is held high with valid low. These show that counting and idle filtering work, and that a single-word packet is not mistaken for an open one. Separate streams each carry one fault: a short packet, a wrong payload value, a start word inside an open packet, and a payload word with no packet open. Each stream should raise err through its own path, and where the fault still leaves the length matched, pkt_count should still advance. Under gap mode the read enable is compared cycle by cycle against an independent model of the LFSR, and a packet is sent through the gaps. A second instance built in priority mode is given the same stream with dav low in mid-packet, which separates the two dav modes.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_BODY
    } rx_state_e;

    localparam logic [15:0] PRN_SEED = 16'hACE1;
endpackage

// File: rtl/pkt_rx_lfsr.sv
module pkt_rx_lfsr
    import pkt_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic bit_o
);
    logic [15:0] s_q;

    always_ff @(posedge clk) begin
        if (rst) s_q <= PRN_SEED;
        else     s_q <= {s_q[14:0], s_q[15] ^ s_q[13] ^ s_q[12] ^ s_q[10]};
    end

    assign bit_o = s_q[0];
endmodule

// File: rtl/pkt_rx_fsm.sv
module pkt_rx_fsm
    import pkt_rx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    input  logic         sop,
    input  logic         eop,
    input  logic [W-1:0] data,
    output logic         in_pkt,
    output logic         good,
    output logic         bad
);
    rx_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] len_q, len_d;
    logic [W-1:0] exp_q, exp_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            exp_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
            exp_q   <= exp_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        exp_d   = exp_q;
        good    = 1'b0;
        bad     = 1'b0;
        if (accept) begin
            if (sop) begin
                if (state_q == ST_BODY) bad = 1'b1;
                len_d = data;
                cnt_d = W'(1);
                exp_d = '0;
                if (eop) begin
                    state_d = ST_IDLE;
                    if (data == W'(1)) good = 1'b1;
                    else               bad  = 1'b1;
                end else begin
                    state_d = ST_BODY;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: bad = 1'b1;
                    ST_BODY: begin
                        if (data != exp_q) bad = 1'b1;
                        exp_d = exp_q + W'(1);
                        cnt_d = cnt_q + W'(1);
                        if (eop) begin
                            state_d = ST_IDLE;
                            if (cnt_q + W'(1) == len_q) good = 1'b1;
                            else                        bad  = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign in_pkt = (state_q == ST_BODY);
endmodule

// File: rtl/pkt_rx_tally.sv
module pkt_rx_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             good,
    input  logic             bad,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (good) count <= count + CNT_W'(1);
            if (bad)  err   <= 1'b1;
        end
    end
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker #(
    parameter int W        = 16,
    parameter int CNT_W    = 16,
    parameter bit PRIORITY = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gap_en,
    input  logic             dav,
    input  logic             valid,
    input  logic             sop,
    input  logic             eop,
    input  logic [W-1:0]     data,
    output logic             rd_en,
    output logic [CNT_W-1:0] pkt_count,
    output logic             err
);
    logic gate_bit;
    logic in_pkt;
    logic dav_ok;
    logic good;
    logic bad;
    logic accept;

    pkt_rx_lfsr u_prn (
        .clk   (clk),
        .rst   (rst),
        .bit_o (gate_bit)
    );

    generate
        if (PRIORITY) begin : g_pri
            assign dav_ok = in_pkt | dav;
        end else begin : g_dat
            assign dav_ok = dav;
        end
    endgenerate

    assign rd_en  = dav_ok & (~gap_en | gate_bit);
    assign accept = rd_en & valid;

    pkt_rx_fsm #(.W(W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .sop    (sop),
        .eop    (eop),
        .data   (data),
        .in_pkt (in_pkt),
        .good   (good),
        .bad    (bad)
    );

    pkt_rx_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .good  (good),
        .bad   (bad),
        .count (pkt_count),
        .err   (err)
    );
endmodule

// File: rtl/pkt_rx_checker_sva.sv
module pkt_rx_checker_sva #(
    parameter int CNT_W    = 16,
    parameter bit PRIORITY = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             gap_en,
    input logic             dav,
    input logic             valid,
    input logic             eop,
    input logic             rd_en,
    input logic             in_pkt,
    input logic             gate_bit,
    input logic [CNT_W-1:0] pkt_count,
    input logic             err
);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R4
    pkt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pkt_count == $past(pkt_count)) || (pkt_count == $past(pkt_count) + CNT_W'(1)));

    // R4
    pkt_eop_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_count != $past(pkt_count)) |-> $past(valid && rd_en && eop));

    // R9
    gap_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (gap_en && rd_en) |-> gate_bit);

    // R10
    dav_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!PRIORITY && !dav) |-> !rd_en);

    // R11
    idle_dav_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_pkt && !dav) |-> !rd_en);
endmodule

bind pkt_rx_checker pkt_rx_checker_sva #(.CNT_W(CNT_W), .PRIORITY(PRIORITY)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .gap_en    (gap_en),
    .dav       (dav),
    .valid     (valid),
    .eop       (eop),
    .rd_en     (rd_en),
    .in_pkt    (in_pkt),
    .gate_bit  (gate_bit),
    .pkt_count (pkt_count),
    .err       (err)
);

// File: tb/pkt_rx_checker_test.sv
module pkt_rx_checker_test;
    localparam int W     = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gap_en = 1'b0;
    logic             dav = 1'b1;
    logic             valid = 1'b0;
    logic             sop = 1'b0;
    logic             eop = 1'b0;
    logic [W-1:0]     data = '0;
    logic             rd_en, rd_en_p;
    logic [CNT_W-1:0] pkt_count, pkt_count_p;
    logic             err, err_p;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_lfsr;

    always #4 clk = ~clk;

    pkt_rx_checker #(.W(W), .CNT_W(CNT_W), .PRIORITY(1'b0)) uut (
        .clk(clk), .rst(rst), .gap_en(gap_en), .dav(dav), .valid(valid),
        .sop(sop), .eop(eop), .data(data), .rd_en(rd_en),
        .pkt_count(pkt_count), .err(err)
    );

    pkt_rx_checker #(.W(W), .CNT_W(CNT_W), .PRIORITY(1'b1)) uut_pri (
        .clk(clk), .rst(rst), .gap_en(gap_en), .dav(dav), .valid(valid),
        .sop(sop), .eop(eop), .data(data), .rd_en(rd_en_p),
        .pkt_count(pkt_count_p), .err(err_p)
    );

    always_ff @(posedge clk) begin
        if (rst) m_lfsr <= 16'hACE1;
        else     m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        valid = 1'b0; sop = 1'b0; eop = 1'b0; data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst = 1'b1; gap_en = 1'b0; dav = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one word at a negedge, hold it until uut accepts it
    task automatic send(input logic s, input logic e, input int d);
        valid = 1'b1; sop = s; eop = e; data = W'(d);
        forever begin
            #1;
            if (rd_en) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input bit gaps);
        send(1'b1, n == 1, n);
        for (int i = 0; i < n - 1; i++) begin
            if (gaps) begin
                idle(); sop = 1'b1; data = 16'h5A5A;
                @(negedge clk);
            end
            send(1'b0, i == n - 2, i);
        end
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pkt_count", int'(pkt_count), 0);
        chk("R1 err", int'(err), 0);
        #1 chk("R1 rd_en with dav high", int'(rd_en), 1);
        dav = 1'b0;
        #1 chk("R10 rd_en with dav low", int'(rd_en), 0);
        dav = 1'b1;
    endtask

    task automatic t_good();
        do_reset();
        send_pkt(4, 1'b0);
        chk("R4 count after one packet", int'(pkt_count), 1);
        send_pkt(1, 1'b0);
        chk("R12 single-word packet", int'(pkt_count), 2);
        send_pkt(2, 1'b1);
        chk("R2 gaps with valid low ignored", int'(err), 0);
        send_pkt(4, 1'b1);
        chk("R5 payload restarts per packet", int'(pkt_count), 4);
        chk("R3 matched lengths no error", int'(err), 0);
    endtask

    task automatic t_len();
        do_reset();
        send(1'b1, 1'b0, 5);
        send(1'b0, 1'b0, 0);
        send(1'b0, 1'b1, 1);
        idle();
        chk("R3 short packet err", int'(err), 1);
        chk("R3 short packet not counted", int'(pkt_count), 0);
    endtask

    task automatic t_payload();
        do_reset();
        send(1'b1, 1'b0, 3);
        send(1'b0, 1'b0, 0);
        send(1'b0, 1'b1, 7);
        idle();
        chk("R5 bad payload err", int'(err), 1);
        chk("R4 length matched still counted", int'(pkt_count), 1);
    endtask

    task automatic t_restart();
        do_reset();
        send(1'b1, 1'b0, 4);
        send(1'b0, 1'b0, 0);
        chk("R6 no err before restart", int'(err), 0);
        send(1'b1, 1'b0, 2);
        send(1'b0, 1'b1, 0);
        idle();
        chk("R6 start inside packet err", int'(err), 1);
        chk("R6 restarted packet counted", int'(pkt_count), 1);
    endtask

    task automatic t_orphan();
        do_reset();
        send(1'b0, 1'b0, 0);
        idle();
        chk("R7 word with no packet open", int'(err), 1);
        send_pkt(3, 1'b0);
        chk("R7 idle after orphan", int'(pkt_count), 1);
        repeat (5) @(negedge clk);
        chk("R8 err stays set", int'(err), 1);
        do_reset();
        chk("R8 reset clears err", int'(err), 0);
    endtask

    task automatic t_gap();
        int mism = 0;
        int lows = 0;
        int highs = 0;
        do_reset();
        gap_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (rd_en !== m_lfsr[0]) mism++;
            if (rd_en) highs++; else lows++;
            @(negedge clk);
        end
        chk("R9 rd_en follows LFSR bit", mism, 0);
        chk("R9 gaps inserted", int'(lows > 0 && highs > 0), 1);
        send_pkt(6, 1'b0);
        chk("R9 packet through gaps", int'(pkt_count), 1);
        chk("R9 no err under gaps", int'(err), 0);
        gap_en = 1'b0;
    endtask

    task automatic t_priority();
        do_reset();
        send(1'b1, 1'b0, 3);
        dav = 1'b0;
        valid = 1'b1; sop = 1'b0; eop = 1'b0; data = 16'd0;
        #1;
        chk("R10 data mode blocks mid-packet", int'(rd_en), 0);
        chk("R11 priority mode ignores dav mid-packet", int'(rd_en_p), 1);
        @(negedge clk);
        eop = 1'b1; data = 16'd1;
        @(negedge clk);
        idle();
        chk("R11 priority packet counted", int'(pkt_count_p), 1);
        chk("R11 priority no err", int'(err_p), 0);
        chk("R10 data mode packet still open", int'(pkt_count), 0);
        valid = 1'b1; sop = 1'b1; data = 16'd2;
        #1 chk("R11 dav gates first word", int'(rd_en_p), 0);
        idle();
        dav = 1'b1;
    endtask

    initial begin
        t_reset();
        t_good();
        t_len();
        t_payload();
        t_restart();
        t_orphan();
        t_gap();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule